// File: doc/BRIEF.md
# Fixed-Latency Hit Clustering Engine

This block takes the hits of one detector event as a stream and hands them back regrouped, so that every hit of one cluster leaves in a single unbroken run. Each hit carries a channel number, a time bin and a payload word. Two hits are neighbours when their channels differ by at most one and their time bins also differ by at most one. A cluster is a group of hits joined through chains of neighbours. The stream must arrive sorted by time bin, and by channel within one time bin. Every channel index must be below the channel count.

An event has two phases, one after the other. While collecting, the engine stores each hit. It links the hit into its cluster in the same cycle, using a per-channel record of the latest hit seen. When one hit touches two clusters, the two are joined into one. When the hit flagged as the event's final hit is taken, the engine stops accepting input. It then walks its linked lists and emits one stored hit per cycle, flagging the first and the last hit of each cluster. Both phases take one cycle per hit, so an event of N hits is finished in 2N cycles, whatever the mix of cluster sizes.

Storage holds a fixed number of hits. Hits beyond that number are accepted and thrown away, and a flag marks the whole output of that event.

Top module: `hitclus_engine`

## Requirements
- R1: Out of reset, `in_ready` is 1 and `out_valid` is 0. `in_ready` stays 1 while collecting and is 0 during every cycle in which `out_valid` is 1. No output appears while collecting.
- R2: `out_valid` rises in the cycle right after the clock edge that accepts a hit with `in_last`=1. It then stays 1 for exactly as many consecutive cycles as the event stored hits. With back-to-back input, an event of N hits therefore takes 2N cycles.
- R3: Every stored hit is emitted exactly once, with the channel, time bin and payload it arrived with.
- R4: Hits joined by neighbour chains (channel difference ≤1 and time-bin difference ≤1) leave as one consecutive run. The run's first hit has `out_first`=1 and its last hit has `out_last`=1; a single-hit cluster has both flags set.
- R5: Clusters leave in the order of their earliest-arriving hit, and each cluster's earliest-arriving hit is the first one emitted for it.
- R6: A hit that neighbours two separate clusters joins both into one cluster. This holds for clusters that met at an earlier time bin and for chains of several joins.
- R7: Channels do not wrap around. Channel 0 and the highest channel are never neighbours, and hits on either edge channel still group with their inner neighbour.
- R8: When an event brings more hits than the capacity `CAP`, only the first `CAP` hits are stored and emitted. `out_overflow` is 1 on every output cycle of that event and 0 on every output cycle of an event that fits.
- R9: The neighbour record is cleared between events, so a hit never joins a cluster of an earlier event.
- R10: Hits on the same channel whose time bins differ by two are not neighbours. Diagonal hits (channel ±1, time bin +1) are neighbours.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input hit present |
| in_ready | output | 1 | Engine is collecting hits |
| in_chan | input | $clog2(NCH) | Channel index of the hit |
| in_time | input | TW | Time bin of the hit |
| in_payload | input | PW | Payload carried with the hit |
| in_last | input | 1 | This hit is the last of the event |
| out_valid | output | 1 | Output hit present |
| out_chan | output | $clog2(NCH) | Channel index of emitted hit |
| out_time | output | TW | Time bin of emitted hit |
| out_payload | output | PW | Payload of emitted hit |
| out_first | output | 1 | First hit of a cluster |
| out_last | output | 1 | Last hit of a cluster |
| out_overflow | output | 1 | Current event lost hits to the capacity limit |

## Verification
All results are due at a fixed distance from the stimulus. The first output hit is present in the cycle after the edge that accepts the flagged final hit, and output then continues for exactly as many cycles as hits were stored. Hits are driven and outputs are sampled on the falling clock edge. The bench checks `out_valid` at the first falling edge after the final hit's accepting edge, then counts the following cycles until it drops. A monitor takes each output hit at the same falling edge and matches it against cluster records that a driver task has queued, in order of earliest hit. These records come from a grouping of the sent hits that the bench computes by itself.

// File: rtl/hitclus_pkg.sv
package hitclus_pkg;

  // Engine phase: collecting hits or streaming them back out.
  typedef enum logic {
    PH_FILL  = 1'b0,
    PH_DRAIN = 1'b1
  } phase_t;

  // What one incoming hit does to the cluster lists.
  typedef enum logic [1:0] {
    LK_NONE   = 2'd0,
    LK_NEW    = 2'd1,
    LK_APPEND = 2'd2,
    LK_MERGE  = 2'd3
  } link_op_t;

endpackage

// File: rtl/hitclus_nbr_table.sv
// Per-channel record of the newest hit: valid bit, time bin, cluster id.
// Three lookups (channel-1, channel, channel+1) are combinational.
module hitclus_nbr_table #(
  parameter int NCH = 64,
  parameter int TW  = 10,
  parameter int IW  = 8,
  parameter int CW  = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic [CW-1:0] lk_chan,
  input  logic [TW-1:0] lk_time,
  output logic          near_l,
  output logic          near_c,
  output logic          near_r,
  output logic [IW-1:0] cid_l,
  output logic [IW-1:0] cid_c,
  output logic [IW-1:0] cid_r,
  input  logic          wr_en,
  input  logic [CW-1:0] wr_chan,
  input  logic [TW-1:0] wr_time,
  input  logic [IW-1:0] wr_cid,
  input  logic          rn_en,
  input  logic [IW-1:0] rn_from,
  input  logic [IW-1:0] rn_to
);

  logic [NCH-1:0] tv;
  logic [TW-1:0]  tt [NCH];
  logic [IW-1:0]  tc [NCH];

  // Recorded hit is still close enough in time to touch the new one.
  function automatic logic in_window(input logic [TW-1:0] seen,
                                     input logic [TW-1:0] now);
    return (seen == now) || (seen == now - TW'(1));
  endfunction

  for (genvar j = 0; j < NCH; j++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tv[j] <= 1'b0;
        tt[j] <= '0;
        tc[j] <= '0;
      end else if (clr) begin
        tv[j] <= 1'b0;
      end else if (wr_en && wr_chan == CW'(j)) begin
        tv[j] <= 1'b1;
        tt[j] <= wr_time;
        tc[j] <= wr_cid;
      end else if (rn_en && tv[j] && tc[j] == rn_from) begin
        tc[j] <= rn_to;
      end
    end
  end

  logic          has_l, has_r;
  logic [CW-1:0] li, ri;

  assign has_l = (lk_chan != '0);
  assign has_r = (lk_chan != CW'(NCH - 1));
  assign li    = has_l ? lk_chan - CW'(1) : lk_chan;
  assign ri    = has_r ? lk_chan + CW'(1) : lk_chan;

  assign near_l = has_l && tv[li] && in_window(tt[li], lk_time);
  assign near_c = tv[lk_chan] && in_window(tt[lk_chan], lk_time);
  assign near_r = has_r && tv[ri] && in_window(tt[ri], lk_time);
  assign cid_l  = tc[li];
  assign cid_c  = tc[lk_chan];
  assign cid_r  = tc[ri];

endmodule

// File: rtl/hitclus_link_store.sv
// Hit storage plus singly linked cluster lists. A cluster's id equals the
// index of its head hit, so only tail pointers and live bits are kept.
module hitclus_link_store
  import hitclus_pkg::*;
#(
  parameter int CAP = 256,
  parameter int IW  = 8,
  parameter int CW  = 6,
  parameter int TW  = 10,
  parameter int PW  = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  input  logic           st_en,
  input  logic [IW-1:0]  st_idx,
  input  logic [CW-1:0]  st_chan,
  input  logic [TW-1:0]  st_time,
  input  logic [PW-1:0]  st_pay,
  input  link_op_t       op,
  input  logic [IW-1:0]  op_a,
  input  logic [IW-1:0]  op_b,
  input  logic [IW-1:0]  rd_idx,
  output logic [CW-1:0]  rd_chan,
  output logic [TW-1:0]  rd_time,
  output logic [PW-1:0]  rd_pay,
  output logic [IW-1:0]  rd_next,
  input  logic [IW-1:0]  cq_id,
  output logic [IW-1:0]  cq_tail,
  output logic [CAP-1:0] live_vec
);

  logic [CW-1:0]  m_ch   [CAP];
  logic [TW-1:0]  m_tm   [CAP];
  logic [PW-1:0]  m_pl   [CAP];
  logic [IW-1:0]  m_nxt  [CAP];
  logic [IW-1:0]  m_tail [CAP];
  logic [CAP-1:0] m_live;

  always_ff @(posedge clk) begin
    if (st_en) begin
      m_ch[st_idx] <= st_chan;
      m_tm[st_idx] <= st_time;
      m_pl[st_idx] <= st_pay;
      case (op)
        LK_NEW: m_tail[st_idx] <= st_idx;
        LK_APPEND: begin
          m_nxt[m_tail[op_a]] <= st_idx;
          m_tail[op_a]        <= st_idx;
        end
        LK_MERGE: begin
          // survivor list, then victim list, then the bridging hit
          m_nxt[m_tail[op_a]] <= op_b;
          m_nxt[m_tail[op_b]] <= st_idx;
          m_tail[op_a]        <= st_idx;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_live <= '0;
    end else if (clr) begin
      m_live <= '0;
    end else if (st_en) begin
      if (op == LK_NEW)   m_live[st_idx] <= 1'b1;
      if (op == LK_MERGE) m_live[op_b]   <= 1'b0;
    end
  end

  assign rd_chan  = m_ch[rd_idx];
  assign rd_time  = m_tm[rd_idx];
  assign rd_pay   = m_pl[rd_idx];
  assign rd_next  = m_nxt[rd_idx];
  assign cq_tail  = m_tail[cq_id];
  assign live_vec = m_live;

endmodule

// File: rtl/hitclus_engine.sv
module hitclus_engine
  import hitclus_pkg::*;
#(
  parameter int CAP = 256,
  parameter int NCH = 64,
  parameter int TW  = 10,
  parameter int PW  = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [$clog2(NCH)-1:0] in_chan,
  input  logic [TW-1:0]          in_time,
  input  logic [PW-1:0]          in_payload,
  input  logic                   in_last,
  output logic                   out_valid,
  output logic [$clog2(NCH)-1:0] out_chan,
  output logic [TW-1:0]          out_time,
  output logic [PW-1:0]          out_payload,
  output logic                   out_first,
  output logic                   out_last,
  output logic                   out_overflow
);

  localparam int IW = $clog2(CAP);
  localparam int CW = $clog2(NCH);
  localparam int NW = IW + 1;

  function automatic logic [IW-1:0] lower_id(input logic [IW-1:0] a,
                                             input logic [IW-1:0] b);
    return (a < b) ? a : b;
  endfunction

  function automatic logic [IW-1:0] upper_id(input logic [IW-1:0] a,
                                             input logic [IW-1:0] b);
    return (a < b) ? b : a;
  endfunction

  // Lowest live cluster head strictly above 'from'.
  function automatic logic [IW-1:0] next_head(input logic [CAP-1:0] lv,
                                              input logic [IW-1:0]  from);
    logic [IW-1:0] r;
    r = from;
    for (int i = CAP - 1; i >= 0; i--) begin
      if (lv[i] && i > int'(from)) r = IW'(i);
    end
    return r;
  endfunction

  phase_t        ph;
  logic [NW-1:0] n_st, n_out;
  logic [IW-1:0] cur, ccid;
  logic          first_q, ovf_q;

  logic          near_l, near_c, near_r;
  logic [IW-1:0] cid_l, cid_c, cid_r;
  link_op_t      lk_op;
  logic [IW-1:0] lk_a, lk_b, lk_cid, h;
  logic [CW-1:0] rd_chan;
  logic [TW-1:0] rd_time;
  logic [PW-1:0] rd_pay;
  logic [IW-1:0] rd_next, cq_tail, nxt_hd;
  logic [CAP-1:0] live_vec;

  // Named internal events, watched by the checker.
  logic ev_accept, ev_room, ev_store, ev_drop, ev_merge;
  logic ev_cl_end, ev_drain_done;

  assign h         = n_st[IW-1:0];
  assign ev_accept = in_valid && (ph == PH_FILL);
  assign ev_room   = (n_st < NW'(CAP));
  assign ev_store  = ev_accept && ev_room;
  assign ev_drop   = ev_accept && !ev_room;
  assign ev_merge  = ev_store && (lk_op == LK_MERGE);
  assign ev_cl_end = (ph == PH_DRAIN) && (cur == cq_tail);
  assign ev_drain_done = (ph == PH_DRAIN) && (n_out + NW'(1) == n_st);
  assign nxt_hd    = next_head(live_vec, ccid);

  always_comb begin
    lk_op = LK_NEW;
    lk_a  = h;
    lk_b  = h;
    if (near_c) begin
      lk_op = LK_APPEND;
      lk_a  = cid_c;
    end else if (near_l && near_r && cid_l != cid_r) begin
      lk_op = LK_MERGE;
      lk_a  = lower_id(cid_l, cid_r);
      lk_b  = upper_id(cid_l, cid_r);
    end else if (near_l) begin
      lk_op = LK_APPEND;
      lk_a  = cid_l;
    end else if (near_r) begin
      lk_op = LK_APPEND;
      lk_a  = cid_r;
    end
    lk_cid = (lk_op == LK_NEW) ? h : lk_a;
  end

  hitclus_nbr_table #(.NCH(NCH), .TW(TW), .IW(IW), .CW(CW)) u_tab (
    .clk(clk), .rst_n(rst_n), .clr(ev_drain_done),
    .lk_chan(in_chan), .lk_time(in_time),
    .near_l(near_l), .near_c(near_c), .near_r(near_r),
    .cid_l(cid_l), .cid_c(cid_c), .cid_r(cid_r),
    .wr_en(ev_store), .wr_chan(in_chan), .wr_time(in_time), .wr_cid(lk_cid),
    .rn_en(ev_merge), .rn_from(lk_b), .rn_to(lk_a)
  );

  hitclus_link_store #(.CAP(CAP), .IW(IW), .CW(CW), .TW(TW), .PW(PW)) u_store (
    .clk(clk), .rst_n(rst_n), .clr(ev_drain_done),
    .st_en(ev_store), .st_idx(h), .st_chan(in_chan), .st_time(in_time),
    .st_pay(in_payload), .op(ev_store ? lk_op : LK_NONE),
    .op_a(lk_a), .op_b(lk_b),
    .rd_idx(cur), .rd_chan(rd_chan), .rd_time(rd_time), .rd_pay(rd_pay),
    .rd_next(rd_next), .cq_id(ccid), .cq_tail(cq_tail), .live_vec(live_vec)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph      <= PH_FILL;
      n_st    <= '0;
      n_out   <= '0;
      cur     <= '0;
      ccid    <= '0;
      first_q <= 1'b1;
      ovf_q   <= 1'b0;
    end else if (ph == PH_FILL) begin
      if (ev_accept) begin
        if (ev_room) n_st  <= n_st + NW'(1);
        else         ovf_q <= 1'b1;
        if (in_last) begin
          ph      <= PH_DRAIN;
          cur     <= '0;
          ccid    <= '0;
          first_q <= 1'b1;
          n_out   <= '0;
        end
      end
    end else begin
      if (ev_drain_done) begin
        ph    <= PH_FILL;
        n_st  <= '0;
        ovf_q <= 1'b0;
      end else begin
        n_out <= n_out + NW'(1);
        if (ev_cl_end) begin
          ccid    <= nxt_hd;
          cur     <= nxt_hd;
          first_q <= 1'b1;
        end else begin
          cur     <= rd_next;
          first_q <= 1'b0;
        end
      end
    end
  end

  assign in_ready     = (ph == PH_FILL);
  assign out_valid    = (ph == PH_DRAIN);
  assign out_chan     = rd_chan;
  assign out_time     = rd_time;
  assign out_payload  = rd_pay;
  assign out_first    = out_valid && first_q;
  assign out_last     = ev_cl_end;
  assign out_overflow = out_valid && ovf_q;

endmodule

// File: rtl/hitclus_checks.sv
module hitclus_checks (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic in_ready,
  input logic in_last,
  input logic out_valid,
  input logic out_first,
  input logic out_last,
  input logic out_overflow,
  input logic ev_store,
  input logic ev_drop,
  input logic ev_drain_done
);

  int unsigned fill_cnt, drain_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_cnt  <= 0;
      drain_cnt <= 0;
    end else if (ev_drain_done) begin
      fill_cnt  <= 0;
      drain_cnt <= 0;
    end else begin
      if (ev_store)  fill_cnt  <= fill_cnt + 1;
      if (out_valid) drain_cnt <= drain_cnt + 1;
    end
  end

  assert_phase_excl_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));

  assert_start_after_last_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_last) |=> (out_valid && out_first));

  assert_drain_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_drain_done |-> (drain_cnt + 1 == fill_cnt));

  assert_first_follows_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_last && !ev_drain_done) |=> out_first);

  assert_done_closes_cluster_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_drain_done |-> out_last);

  assert_flags_need_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_first || out_last) |-> out_valid);

  assert_ovf_after_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_drop && in_last) |=> out_overflow);

  assert_ovf_steady_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(out_valid)) |-> $stable(out_overflow));

endmodule

bind hitclus_engine hitclus_checks u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_last(in_last), .out_valid(out_valid), .out_first(out_first),
  .out_last(out_last), .out_overflow(out_overflow), .ev_store(ev_store),
  .ev_drop(ev_drop), .ev_drain_done(ev_drain_done)
);

// File: tb/hitclus_engine_tb.sv
module hitclus_engine_tb;

  localparam int CLK_NS = 10;
  localparam int CAP    = 256;
  localparam int NCH    = 64;
  localparam int TW     = 10;
  localparam int PW     = 16;
  localparam int CW     = $clog2(NCH);
  localparam int MAXH   = 512;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0, in_last = 1'b0;
  logic          in_ready;
  logic [CW-1:0] in_chan = '0;
  logic [TW-1:0] in_time = '0;
  logic [PW-1:0] in_payload = '0;
  logic          out_valid, out_first, out_last, out_overflow;
  logic [CW-1:0] out_chan;
  logic [TW-1:0] out_time;
  logic [PW-1:0] out_payload;

  hitclus_engine #(.CAP(CAP), .NCH(NCH), .TW(TW), .PW(PW)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_chan(in_chan), .in_time(in_time), .in_payload(in_payload),
    .in_last(in_last), .out_valid(out_valid), .out_chan(out_chan),
    .out_time(out_time), .out_payload(out_payload), .out_first(out_first),
    .out_last(out_last), .out_overflow(out_overflow)
  );

  always #(CLK_NS / 2) clk = ~clk;

  int n_checks = 0, n_fail = 0;
  int ev_n = 0, n_exp = 0, exp_clusters = 0, n_seen = 0, n_clus = 0;
  int ev_ch [MAXH];
  int ev_tm [MAXH];
  int parent [MAXH];
  bit seen [MAXH];
  bit exp_ovf = 1'b0;
  int cur_label = -1, cur_cnt = 0, cur_size = 0;

  typedef struct { int head; int size; } clus_t;
  clus_t exp_q [$];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int root_of(input int i);
    int k = i;
    while (parent[k] != k) k = parent[k];
    return k;
  endfunction

  function automatic bit touching(input int a, input int b);
    int dc = ev_ch[a] - ev_ch[b];
    int dt = ev_tm[a] - ev_tm[b];
    return (dc * dc <= 1) && (dt * dt <= 1);
  endfunction

  task automatic add(input int c, input int t);
    if (ev_n < MAXH) begin
      ev_ch[ev_n] = c;
      ev_tm[ev_n] = t;
      ev_n++;
    end
  endtask

  // Independent grouping: union of every touching pair, root = lowest index.
  task automatic build_expect();
    n_exp   = (ev_n > CAP) ? CAP : ev_n;
    exp_ovf = (ev_n > CAP);
    for (int i = 0; i < n_exp; i++) parent[i] = i;
    for (int j = 0; j < n_exp; j++) begin
      for (int i = 0; i < j; i++) begin
        if (touching(i, j)) begin
          int ri = root_of(i);
          int rj = root_of(j);
          if (ri < rj) parent[rj] = ri;
          else if (rj < ri) parent[ri] = rj;
        end
      end
    end
    exp_q.delete();
    for (int i = 0; i < n_exp; i++) begin
      if (root_of(i) == i) begin
        clus_t c;
        c.head = i;
        c.size = 0;
        for (int k = 0; k < n_exp; k++) if (root_of(k) == i) c.size++;
        exp_q.push_back(c);
      end
    end
    exp_clusters = exp_q.size();
  endtask

  task automatic run_event(input string rtag, input int want_clusters);
    int cnt;
    build_expect();
    if (want_clusters >= 0)
      check(exp_clusters == want_clusters, rtag, "bench grouping", exp_clusters, want_clusters);
    for (int i = 0; i < MAXH; i++) seen[i] = 1'b0;
    n_seen = 0;
    n_clus = 0;
    for (int k = 0; k < ev_n; k++) begin
      @(negedge clk);
      in_valid   = 1'b1;
      in_chan    = CW'(ev_ch[k]);
      in_time    = TW'(ev_tm[k]);
      in_payload = PW'(k);
      in_last    = (k == ev_n - 1);
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_last  = 1'b0;
    check(out_valid == 1'b1, "R2", "out_valid one cycle after final hit", out_valid, 1);
    cnt = 0;
    while (out_valid) begin
      check(in_ready == 1'b0, "R1", "in_ready during output", in_ready, 0);
      cnt++;
      @(negedge clk);
    end
    check(cnt == n_exp, "R2", "output cycles", cnt, n_exp);
    check(n_seen == n_exp, "R3", "distinct hits emitted", n_seen, n_exp);
    check(exp_q.size() == 0, "R4", "clusters left unmatched", exp_q.size(), 0);
    check(n_clus == exp_clusters, rtag, "cluster count", n_clus, exp_clusters);
    check(in_ready == 1'b1, "R1", "in_ready after output", in_ready, 1);
    ev_n = 0;
  endtask

  // Monitor: pops one expected cluster per start flag and checks every hit.
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      int idx;
      idx = int'(out_payload);
      check(idx < n_exp, "R3", "payload index in range", idx, n_exp - 1);
      check(out_overflow == exp_ovf, "R8", "overflow flag", out_overflow, exp_ovf);
      if (idx < n_exp) begin
        check(!seen[idx], "R3", "hit emitted once", idx, -1);
        if (!seen[idx]) n_seen++;
        seen[idx] = 1'b1;
        check(int'(out_chan) == ev_ch[idx] && int'(out_time) == ev_tm[idx], "R3",
              "channel*1024+time", int'(out_chan) * 1024 + int'(out_time),
              ev_ch[idx] * 1024 + ev_tm[idx]);
        if (out_first) begin
          n_clus++;
          if (exp_q.size() == 0) begin
            check(1'b0, "R4", "unexpected cluster start", idx, -1);
            cur_label = -1;
          end else begin
            clus_t c;
            c = exp_q.pop_front();
            check(idx == c.head, "R5", "cluster head", idx, c.head);
            cur_label = c.head;
            cur_size  = c.size;
          end
          cur_cnt = 1;
        end else begin
          check(root_of(idx) == cur_label, "R4", "hit in current cluster", root_of(idx), cur_label);
          cur_cnt++;
        end
        if (out_last)
          check(cur_cnt == cur_size, "R4", "cluster length", cur_cnt, cur_size);
      end
    end
  end

  initial begin
    #(CLK_NS * 100000);
    n_fail++;
    $display("FAIL R2 watchdog expired: actual %0d expected %0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(in_ready == 1'b1 && out_valid == 1'b0, "R1", "reset ready/valid",
          {in_ready, out_valid}, 2);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(in_ready == 1'b1 && out_valid == 1'b0, "R1", "idle ready/valid",
          {in_ready, out_valid}, 2);

    // R4: single hit, both flags on one cycle
    add(9, 3);
    run_event("R4", 1);
    // R4: a horizontal streak
    for (int c = 3; c <= 7; c++) add(c, 0);
    run_event("R4", 1);
    // R4: two columns interleaved in time must still leave unbroken
    for (int t = 0; t < 5; t++) begin add(2, t); add(10, t); end
    run_event("R4", 2);
    // R6: U shape joined at a later time bin
    add(5, 0); add(7, 0); add(5, 1); add(7, 1); add(6, 2);
    run_event("R6", 1);
    // R6: two same-time bridges in one event
    add(4, 0); add(6, 0); add(30, 0); add(32, 0); add(5, 1); add(31, 1);
    run_event("R6", 2);
    // R6: chain of joins that relies on renamed records
    add(10, 0); add(12, 0); add(14, 0); add(11, 1); add(13, 1);
    run_event("R6", 1);
    // R7: edge channels do not wrap; top edge groups inward
    add(0, 0); add(63, 0); add(62, 1);
    run_event("R7", 2);
    // R10: gap of two bins separates; diagonal joins
    add(3, 0); add(20, 0); add(21, 1); add(3, 2);
    run_event("R10", 3);
    // R9: record must be empty at the start of the next event
    add(5, 0);
    run_event("R9", 1);
    add(20, 0); add(6, 0);
    run_event("R9", 2);
    // R5: random sparse events
    for (int e = 0; e < 4; e++) begin
      for (int t = 0; t < 12; t++)
        for (int c = 0; c < NCH; c++)
          if ($urandom_range(99) < 12) add(c, t);
      if (ev_n == 0) add(0, 0);
      run_event("R5", -1);
    end
    // R8: over capacity, columns with gaps every eighth channel
    for (int t = 0; t < 5; t++)
      for (int c = 0; c < NCH; c++)
        if (c % 8 != 3) add(c, t);
    run_event("R8", -1);
    // R8: the next event fits and must not carry the flag
    add(40, 1); add(41, 1);
    run_event("R8", 1);

    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule